// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host bridge. A host-side agent reaches it through one byte-addressed access port. Each access names a starting offset and a size of one, two or four bytes. Data moves little-endian, so the byte at the starting offset sits in bits [7:0]. Every byte offset has its own write rule: it is stored as written, stored through a mask with some bits forced to one, ignored, or cleared where a one is written.

One strap input picks between two bridge personalities, a newer one and an older one. The two differ in their write masks and in a few reset values. The seven shadow-memory attribute bytes drive a one-cycle pulse when a write really changes one of them, so the memory map outside this block knows when to rebuild. The SMRAM control byte belongs to a separate block. Here it reads as zero and ignores writes.

Top module: `hbcfg_regfile`

## Requirements
- R1: Asynchronous active-low reset loads 0x04=0x06, 0x05=0x00, 0x07=0x02, 0x53=0x80, 0x57=0x01. With `cfg_newer`=1 it also loads 0x06=0x80, 0x51=0x01 and 0x58=0x10; with `cfg_newer`=0 those three bytes are 0x00. Every other byte, including 0x59–0x5F, resets to 0x00.
- R2: `acc_size` encodes 0 = one byte, 1 = two bytes, 2 = four bytes and 3 = no access. Lane i covers offset `acc_addr`+i and is placed at `rd_data`[8i+7:8i]. A lane whose offset would pass 0xFF, every lane outside the size, and every lane under size code 3 reads as zero and writes nothing. Reads are combinational and have no side effects.
- R3: Offsets that no other requirement names store the written byte unchanged.
- R4: Writes to any byte in 0x10–0x33 are discarded.
- R5: A write to 0x04 stores (d & 0x40) | 0x06 in the newer personality and (d & 0x02) | 0x04 in the older one.
- R6: 0x05 stores d & 0x01 in the newer personality and ignores writes in the older one.
- R7: 0x07 is write-one-to-clear: it becomes old & ~(d & M), with M = 0xF9 in the newer personality and M = 0x30 in the older one.
- R8: 0x0D stores d & 0xF8. 0x06, 0x0C and 0x0F ignore writes.
- R9: 0x50 stores d & 0x70 in the newer personality and d & 0xEF in the older one. 0x51 stores (d & 0x80) | 0x01 in the newer personality and ignores writes in the older one.
- R10: Offset 0x72 ignores writes and reads 0x00.
- R11: `remap_pulse` is high for exactly the one cycle after a write edge in which at least one written lane at 0x59–0x5F carried a byte different from the value stored there. Otherwise it is low.
- R12: In a multi-byte write, each lane applies the rule of its own offset independently, and compares against its own old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_newer | input | 1 | Personality strap: 1 = newer bridge, 0 = older bridge |
| wr_en | input | 1 | Write strobe for the current access |
| acc_addr | input | 8 | Starting byte offset of the access |
| acc_size | input | 2 | Access size code (see R2) |
| wr_data | input | 32 | Write data, little-endian lanes |
| rd_data | output | 32 | Read data, little-endian lanes, zero in unused lanes |
| remap_pulse | output | 1 | One-cycle pulse after an attribute byte changed |

## Verification
Two things can happen in the same write: several lanes take different rules, and an attribute change raises the pulse. An unaligned two- or four-byte write that straddles the edge of the attribute range makes this happen. So does a write that covers an attribute byte together with a masked or read-only neighbour. Each lane is judged by reading back the whole access and comparing every byte with the model's rule for that byte. The pulse is compared with the model's verdict on whether any attribute lane differed, one cycle after the write edge. Writing the same byte twice in a row, across every offset, checks that an unchanged attribute value raises no pulse.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

  localparam int CFG_AW = 8;
  localparam int CFG_NL = 4;

  localparam logic [7:0] WIN_LO  = 8'h10;
  localparam logic [7:0] WIN_HI  = 8'h33;
  localparam logic [7:0] ATTR_LO = 8'h59;
  localparam logic [7:0] ATTR_HI = 8'h5F;
  localparam logic [7:0] SMM_OFS = 8'h72;

  typedef enum logic [3:0] {
    RL_PLAIN,
    RL_WINDOW,
    RL_CMD_LO,
    RL_CMD_HI,
    RL_STAT_HI,
    RL_LAT,
    RL_RO,
    RL_ARB0,
    RL_ARB1,
    RL_SMM,
    RL_ATTR
  } rule_e;

  // Which write rule governs a given byte offset.
  function automatic rule_e rule_of(logic [7:0] a);
    rule_e r;
    if (a >= WIN_LO && a <= WIN_HI) r = RL_WINDOW;
    else if (a >= ATTR_LO && a <= ATTR_HI) r = RL_ATTR;
    else begin
      case (a)
        8'h04:               r = RL_CMD_LO;
        8'h05:               r = RL_CMD_HI;
        8'h07:               r = RL_STAT_HI;
        8'h0D:               r = RL_LAT;
        8'h06, 8'h0C, 8'h0F: r = RL_RO;
        8'h50:               r = RL_ARB0;
        8'h51:               r = RL_ARB1;
        SMM_OFS:             r = RL_SMM;
        default:             r = RL_PLAIN;
      endcase
    end
    return r;
  endfunction

  // New stored value of one byte given its rule, personality, old value and data.
  function automatic logic [7:0] apply_rule(rule_e r, logic newer,
                                            logic [7:0] old, logic [7:0] d);
    logic [7:0] v;
    case (r)
      RL_PLAIN:   v = d;
      RL_ATTR:    v = d;
      RL_CMD_LO:  v = newer ? ((d & 8'h40) | 8'h06) : ((d & 8'h02) | 8'h04);
      RL_CMD_HI:  v = newer ? (d & 8'h01) : old;
      RL_STAT_HI: v = old & ~(d & (newer ? 8'hF9 : 8'h30));
      RL_LAT:     v = d & 8'hF8;
      RL_ARB0:    v = newer ? (d & 8'h70) : (d & 8'hEF);
      RL_ARB1:    v = newer ? ((d & 8'h80) | 8'h01) : old;
      default:    v = old;
    endcase
    return v;
  endfunction

  // Reset value of one byte.
  function automatic logic [7:0] reset_of(logic [7:0] a, logic newer);
    logic [7:0] v;
    case (a)
      8'h04:   v = 8'h06;
      8'h07:   v = 8'h02;
      8'h53:   v = 8'h80;
      8'h57:   v = 8'h01;
      8'h06:   v = newer ? 8'h80 : 8'h00;
      8'h51:   v = newer ? 8'h01 : 8'h00;
      8'h58:   v = newer ? 8'h10 : 8'h00;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // Number of lanes covered by a size code.
  function automatic int lanes_of(logic [1:0] sz);
    int n;
    case (sz)
      2'd0:    n = 1;
      2'd1:    n = 2;
      2'd2:    n = 4;
      default: n = 0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hbcfg_lane.sv
module hbcfg_lane
  import hbcfg_pkg::*;
#(
  parameter int AW   = CFG_AW,
  parameter int NL   = CFG_NL,
  parameter int LANE = 0
) (
  input  logic [AW-1:0]   base,
  input  logic [1:0]      size,
  input  logic [8*NL-1:0] data,
  output logic            valid,
  output logic [AW-1:0]   addr,
  output logic [7:0]      wbyte
);
  localparam int DEPTH = 1 << AW;

  logic [AW:0] sum;

  always_comb begin
    sum   = {1'b0, base} + (AW+1)'(LANE);
    addr  = sum[AW-1:0];
    valid = (LANE < lanes_of(size)) && (int'(sum) < DEPTH);
    wbyte = data[8*LANE +: 8];
  end
endmodule

// File: rtl/hbcfg_store.sv
module hbcfg_store
  import hbcfg_pkg::*;
#(
  parameter int AW = CFG_AW,
  parameter int NL = CFG_NL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  newer,
  input  logic                  wr_en,
  input  logic [NL-1:0]         lane_valid,
  input  logic [NL-1:0][AW-1:0] lane_addr,
  input  logic [NL-1:0][7:0]    lane_wbyte,
  output logic [NL-1:0][7:0]    lane_rbyte,
  output logic [NL-1:0]         attr_chg
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= reset_of(8'(k), newer);
    end else if (wr_en) begin
      for (int i = 0; i < NL; i++) begin
        if (lane_valid[i])
          mem[lane_addr[i]] <= apply_rule(rule_of(8'(lane_addr[i])), newer,
                                          mem[lane_addr[i]], lane_wbyte[i]);
      end
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_rd
    assign lane_rbyte[g] = mem[lane_addr[g]];
    assign attr_chg[g]   = wr_en && lane_valid[g] &&
                           (rule_of(8'(lane_addr[g])) == RL_ATTR) &&
                           (lane_wbyte[g] != mem[lane_addr[g]]);
  end
endmodule

// File: rtl/hbcfg_remap.sv
module hbcfg_remap #(
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] attr_chg,
  output logic          pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= |attr_chg;
  end
endmodule

// File: rtl/hbcfg_regfile.sv
module hbcfg_regfile
  import hbcfg_pkg::*;
#(
  parameter int AW = CFG_AW,
  parameter int NL = CFG_NL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_newer,
  input  logic            wr_en,
  input  logic [AW-1:0]   acc_addr,
  input  logic [1:0]      acc_size,
  input  logic [8*NL-1:0] wr_data,
  output logic [8*NL-1:0] rd_data,
  output logic            remap_pulse
);
  logic [NL-1:0]         lane_valid;
  logic [NL-1:0][AW-1:0] lane_addr;
  logic [NL-1:0][7:0]    lane_wbyte;
  logic [NL-1:0][7:0]    lane_rbyte;
  logic [NL-1:0]         attr_chg;
  logic                  attr_change_any;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    hbcfg_lane #(.AW(AW), .NL(NL), .LANE(g)) u_lane (
      .base  (acc_addr),
      .size  (acc_size),
      .data  (wr_data),
      .valid (lane_valid[g]),
      .addr  (lane_addr[g]),
      .wbyte (lane_wbyte[g])
    );
    assign rd_data[8*g +: 8] = lane_valid[g] ? lane_rbyte[g] : 8'h00;
  end

  hbcfg_store #(.AW(AW), .NL(NL)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .newer      (cfg_newer),
    .wr_en      (wr_en),
    .lane_valid (lane_valid),
    .lane_addr  (lane_addr),
    .lane_wbyte (lane_wbyte),
    .lane_rbyte (lane_rbyte),
    .attr_chg   (attr_chg)
  );

  assign attr_change_any = |attr_chg;

  hbcfg_remap #(.NL(NL)) u_remap (
    .clk      (clk),
    .rst_n    (rst_n),
    .attr_chg (attr_chg),
    .pulse    (remap_pulse)
  );
endmodule

// File: rtl/hbcfg_chk.sv
module hbcfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_newer,
  input logic        wr_en,
  input logic [7:0]  acc_addr,
  input logic [1:0]  acc_size,
  input logic [31:0] rd_data,
  input logic        remap_pulse,
  input logic        attr_change_any
);
  // R11
  remap_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |-> $past(wr_en));

  // R11
  remap_follows_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attr_change_any |=> remap_pulse);

  // R11
  remap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_change_any |=> !remap_pulse);

  // R2
  nosize_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'd3) |-> (rd_data == 32'h0));

  // R2
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'd0) |-> (rd_data[31:8] == 24'h0));

  // R5
  cmd_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'd0 && acc_addr == 8'h04) |->
      (cfg_newer ? (rd_data[2:1] == 2'b11) : rd_data[2]));

  // R10
  smm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'd0 && acc_addr == 8'h72) |-> (rd_data[7:0] == 8'h00));

  // R4
  window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'd0 && acc_addr >= 8'h10 && acc_addr <= 8'h33) |->
      (rd_data[7:0] == 8'h00));
endmodule

bind hbcfg_regfile hbcfg_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_newer       (cfg_newer),
  .wr_en           (wr_en),
  .acc_addr        (acc_addr),
  .acc_size        (acc_size),
  .rd_data         (rd_data),
  .remap_pulse     (remap_pulse),
  .attr_change_any (attr_change_any)
);

// File: tb/sim_hbcfg_regfile.sv
`timescale 1ns/1ps
module sim_hbcfg_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_newer = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  acc_addr = 8'h00;
  logic [1:0]  acc_size = 2'd0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        remap_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m [256];

  always #2.5 clk = ~clk;

  hbcfg_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cfg_newer(cfg_newer), .wr_en(wr_en),
    .acc_addr(acc_addr), .acc_size(acc_size), .wr_data(wr_data),
    .rd_data(rd_data), .remap_pulse(remap_pulse)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s addr=%02h size=%0d act=%08h exp=%08h", tag, acc_addr, acc_size, act, exp);
    end
  endtask

  function automatic string tag_of(int a);
    if (a >= 16 && a <= 51) return "R4";
    if (a >= 89 && a <= 95) return "R11";
    if (a == 4) return "R5";
    if (a == 5) return "R6";
    if (a == 7) return "R7";
    if (a == 6 || a == 12 || a == 13 || a == 15) return "R8";
    if (a == 80 || a == 81) return "R9";
    if (a == 114) return "R10";
    return "R3";
  endfunction

  function automatic logic [7:0] rst_val(int a, bit nw);
    if (a == 4) return 8'h06;
    if (a == 7) return 8'h02;
    if (a == 83) return 8'h80;
    if (a == 87) return 8'h01;
    if (nw && a == 6) return 8'h80;
    if (nw && a == 81) return 8'h01;
    if (nw && a == 88) return 8'h10;
    return 8'h00;
  endfunction

  function automatic logic [7:0] next_val(int a, bit nw, logic [7:0] o, logic [7:0] d);
    if (a >= 16 && a <= 51) return o;
    if (a == 6 || a == 12 || a == 15 || a == 114) return o;
    if (a == 4)  return nw ? {1'b0, d[6], 3'b000, 3'b110} : {5'b0, 1'b1, d[1], 1'b0};
    if (a == 5)  return nw ? {7'b0, d[0]} : o;
    if (a == 7)  return nw ? (o & ~(d & 8'b1111_1001)) : (o & ~(d & 8'b0011_0000));
    if (a == 13) return {d[7:3], 3'b000};
    if (a == 80) return nw ? {1'b0, d[6:4], 4'b0} : {d[7:5], 1'b0, d[3:0]};
    if (a == 81) return nw ? {d[7], 6'b0, 1'b1} : o;
    return d;
  endfunction

  function automatic int nlanes(logic [1:0] s);
    return (s == 2'd3) ? 0 : (1 << s);
  endfunction

  function automatic logic [31:0] exp_read(int a, logic [1:0] s);
    logic [31:0] v = 32'h0;
    for (int i = 0; i < nlanes(s); i++)
      if (a + i < 256) v[8*i +: 8] = m[a+i];
    return v;
  endfunction

  task automatic do_reset(bit nw);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; cfg_newer = nw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) m[a] = rst_val(a, nw);
    @(negedge clk);
    chk(remap_pulse == 1'b0, "R1", {31'b0, remap_pulse}, 32'h0);
    for (int a = 0; a < 256; a++) begin
      acc_addr = 8'(a); acc_size = 2'd0;
      #1;
      chk(rd_data == {24'h0, m[a]}, "R1", rd_data, {24'h0, m[a]});
      @(negedge clk);
    end
  endtask

  task automatic rd_check(int a, logic [1:0] s, string tag);
    logic [31:0] e;
    acc_addr = 8'(a); acc_size = s; wr_en = 1'b0;
    #1;
    e = exp_read(a, s);
    chk(rd_data == e, tag, rd_data, e);
    #1;
    chk(rd_data == e, "R2", rd_data, e);
  endtask

  task automatic do_write(int a, logic [1:0] s, logic [31:0] d, string tag);
    bit ep = 1'b0;
    for (int i = 0; i < nlanes(s); i++) begin
      if (a + i < 256) begin
        if (a + i >= 89 && a + i <= 95 && d[8*i +: 8] != m[a+i]) ep = 1'b1;
        m[a+i] = next_val(a + i, cfg_newer, m[a+i], d[8*i +: 8]);
      end
    end
    @(negedge clk);
    acc_addr = 8'(a); acc_size = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(remap_pulse == ep, "R11", {31'b0, remap_pulse}, {31'b0, ep});
    rd_check(a, s, tag);
    if (ep) begin
      @(negedge clk);
      chk(remap_pulse == 1'b0, "R11", {31'b0, remap_pulse}, 32'h0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pats [5];
    pats[0] = 8'hFF; pats[1] = 8'hFF; pats[2] = 8'h00; pats[3] = 8'hA5; pats[4] = 8'h5A;
    for (int v = 0; v < 2; v++) begin
      do_reset(v[0] == 1'b0);
      for (int p = 0; p < 5; p++)
        for (int a = 0; a < 256; a++)
          do_write(a, 2'd0, {24'h0, pats[p]}, tag_of(a));
      for (int a = 0; a < 256; a++)
        do_write(a, 2'd2, {8'(a), ~8'(a), 8'(a) ^ 8'h3C, 8'(a) + 8'h11}, "R12");
      for (int a = 1; a < 256; a += 2)
        do_write(a, 2'd1, {16'h0, 8'(a) ^ 8'hC3, ~8'(a)}, "R12");
      do_write(8'h57, 2'd2, 32'h77665544, "R12");
      do_write(8'h57, 2'd2, 32'h77665544, "R12");
      do_write(8'h5E, 2'd2, 32'h00000000, "R12");
      do_write(8'h0E, 2'd2, 32'hFFFFFFFF, "R4");
      do_write(8'hFE, 2'd2, 32'hDEADBEEF, "R2");
      rd_check(8'hFD, 2'd2, "R2");
      do_write(8'h40, 2'd3, 32'h12345678, "R2");
      rd_check(8'h40, 2'd0, "R2");
      do_write(8'h5A, 2'd3, 32'hFFFFFFFF, "R11");
      rd_check(8'h5A, 2'd2, "R2");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule